// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a word-interleaved scratchpad that many lanes share. In one handshake it takes a request for all lanes at once. The request is either a load or a store and carries an active-lane mask, plus one word address and one write word for each lane. Every address selects a bank through its low address bits. When two active lanes need different words that sit in the same bank, they cannot be served together. The block therefore splits the request into passes that it runs one after another. In each pass it serves at most one distinct word per bank. Lanes that name exactly the same word never conflict: that word is accessed once and its value goes to every one of those lanes.

The block holds a single request at a time. It drops `req_ready` until the last pass has been served. It then returns the read word of every lane together, marks that cycle with a one-cycle `done` pulse, and reports the number of passes the request took. A lane that the mask excludes takes no part in the bank count, writes nothing and reads back zero. When several active lanes store to the same word, the value from the highest-numbered of those lanes is kept.

Top module: `spad_serializer`

## Requirements
- R1: The bank of an address is its low 5 bits (address mod 32), and the row inside that bank is the remaining upper bits. A word stored at an address is returned by a later load of that same address.
- R2: A request completes in exactly one pass when each active lane uses a different bank or shares its exact address with another lane.
- R3: Active lanes that load the same address all receive that word. Sharing an address does not add a pass.
- R4: The reported pass count equals the largest number of distinct addresses that the active lanes request within any one bank.
- R5: Lanes outside the mask do not count toward conflicts and read back zero. On a store they leave memory unchanged.
- R6: When several active lanes store to the same word, the word ends up holding the data of the highest-numbered of those lanes.
- R7: `req_ready` is low from the cycle after acceptance until `done` is high. `done` is high for exactly one cycle, P+1 rising edges after the accepting edge, where P is the pass count.
- R8: Each request is judged for conflicts on its own lanes only. Requests issued back to back with addresses that collide across requests each take the single pass that their own lanes need.
- R9: A request with an all-zero mask completes with pass count 0 and all read data zero.
- R10: A store request returns zero read data on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mask | input | 32 | Active-lane mask, bit i = lane i |
| req_addr | input | 320 | Word address of each lane, lane i in bits [10i+9:10i] |
| req_wdata | input | 1024 | Store data of each lane, lane i in bits [32i+31:32i] |
| done | output | 1 | One-cycle pulse: results are valid |
| rdata | output | 1024 | Read data of each lane, same packing as req_wdata |
| pass_count | output | 6 | Number of passes of the finished request, valid with done |

## Verification
The assertions assume that `req_valid` is raised only together with known address, mask and store inputs, and that these inputs are valid at the accepting edge. They also assume that the reset is held long enough for its synchronizer to flush. The stimulus keeps to this. It raises `req_valid` at a falling edge only while `req_ready` is high, and drops it at the next falling edge. Before any load, the bench writes every scratchpad word, so that no load ever returns uninitialized RAM content for the scoreboard to compare against.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } spad_state_e;

endpackage

// File: rtl/spad_bank_pick.sv
module spad_bank_pick #(
  parameter int LANES   = 32,
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter int BW      = 5,
  parameter int BANK_ID = 0,
  localparam int RW     = AW - BW
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES*DW-1:0] wdata_flat,
  output logic                en,
  output logic [RW-1:0]       row,
  output logic [DW-1:0]       wd,
  output logic [LANES-1:0]    hit
);

  logic [AW-1:0] lead_addr;
  logic          lead_found;

  // lowest pending lane in this bank sets the word served in this pass
  always_comb begin
    lead_found = 1'b0;
    lead_addr  = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pending[k] && (addr_flat[k*AW +: BW] == BW'(BANK_ID))) begin
        lead_found = 1'b1;
        lead_addr  = addr_flat[k*AW +: AW];
      end
    end
  end

  // every pending lane on that same word rides along; the last one supplies store data
  always_comb begin
    hit = '0;
    wd  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lead_found && pending[l] && (addr_flat[l*AW +: AW] == lead_addr)) begin
        hit[l] = 1'b1;
        wd     = wdata_flat[l*DW +: DW];
      end
    end
  end

  assign en  = lead_found;
  assign row = lead_addr[AW-1:BW];

endmodule

// File: rtl/spad_bank_ram.sv
module spad_bank_ram #(
  parameter int DW    = 32,
  parameter int RW    = 5,
  localparam int DEPTH = 1 << RW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[row] <= wd;
      end else begin
        rd <= mem[row];
      end
    end
  end

endmodule

// File: rtl/spad_serializer.sv
module spad_serializer
  import spad_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = AW - BW,
  localparam int PCW  = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                done,
  output logic [LANES*DW-1:0] rdata,
  output logic [PCW-1:0]      pass_count
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  spad_state_e         state_q, state_d;
  logic [LANES-1:0]    pending_q, pending_d;
  logic [LANES-1:0]    served_q, served_d;
  logic [PCW-1:0]      passes_q, passes_d;
  logic                done_q, done_d;
  logic [LANES*DW-1:0] rdata_q, rdata_d;
  logic                store_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;

  logic                accept;
  logic                issue;
  logic [LANES-1:0]    served;

  logic [BANKS-1:0][LANES-1:0] bank_hit;
  logic [BANKS-1:0][DW-1:0]    bank_rd;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign issue     = (state_q == ST_BUSY);

  // one selector and one single-port RAM per bank
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          pick_en;
    logic [RW-1:0] pick_row;
    logic [DW-1:0] pick_wd;

    spad_bank_pick #(
      .LANES(LANES), .AW(AW), .DW(DW), .BW(BW), .BANK_ID(b)
    ) u_pick (
      .pending   (pending_q),
      .addr_flat (addr_q),
      .wdata_flat(wdata_q),
      .en        (pick_en),
      .row       (pick_row),
      .wd        (pick_wd),
      .hit       (bank_hit[b])
    );

    spad_bank_ram #(.DW(DW), .RW(RW)) u_ram (
      .clk(clk),
      .en (pick_en && issue),
      .we (store_q),
      .row(pick_row),
      .wd (pick_wd),
      .rd (bank_rd[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) begin
      served = served | bank_hit[b];
    end
  end

  // next state
  always_comb begin
    state_d   = state_q;
    pending_d = pending_q;
    served_d  = '0;
    passes_d  = passes_q;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          pending_d = req_mask;
          passes_d  = '0;
          state_d   = (req_mask == '0) ? ST_DRAIN : ST_BUSY;
        end
      end
      ST_BUSY: begin
        pending_d = pending_q & ~served;
        served_d  = served;
        passes_d  = passes_q + PCW'(1);
        if ((pending_q & ~served) == '0) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // read data lands one cycle after the pass that fetched it
  always_comb begin
    rdata_d = rdata_q;
    if (accept) begin
      rdata_d = '0;
    end else if (!store_q) begin
      for (int l = 0; l < LANES; l++) begin
        if (served_q[l]) begin
          rdata_d[l*DW +: DW] = bank_rd[addr_q[l*AW +: BW]];
        end
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      served_q  <= '0;
      passes_q  <= '0;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      pending_q <= pending_d;
      served_q  <= served_d;
      passes_q  <= passes_d;
      done_q    <= done_d;
      rdata_q   <= rdata_d;
    end
  end

  // request capture, enabled by acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      store_q <= req_store;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign done       = done_q;
  assign rdata      = rdata_q;
  assign pass_count = passes_q;

endmodule

// File: rtl/spad_serializer_chk.sv
module spad_serializer_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int PCW   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [LANES-1:0]    req_mask,
  input logic                done,
  input logic [LANES*DW-1:0] rdata,
  input logic [PCW-1:0]      pass_count
);

  logic                inflight;
  logic [PCW+1:0]      edges;
  logic [LANES-1:0]    mask_seen;
  logic [LANES*DW-1:0] lane_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight  <= 1'b0;
      edges     <= '0;
      mask_seen <= '0;
    end else if (req_valid && req_ready) begin
      inflight  <= 1'b1;
      edges     <= '0;
      mask_seen <= req_mask;
    end else if (inflight) begin
      if (done) begin
        inflight <= 1'b0;
      end else begin
        edges <= edges + 1'b1;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lane_keep[l*DW +: DW] = {DW{mask_seen[l]}};
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inflight && (edges == ((PCW+2)'(pass_count) + 1'b1))));

  // R7
  busy_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> inflight);

  // R4
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass_count <= PCW'(LANES)));

  // R5
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rdata & ~lane_keep) == '0));

  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mask_seen == '0)) |-> (pass_count == '0));

  // R2
  some_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mask_seen != '0)) |-> (pass_count != '0));

endmodule

bind spad_serializer spad_serializer_chk #(
  .LANES(LANES), .DW(DW), .PCW(PCW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mask  (req_mask),
  .done      (done),
  .rdata     (rdata),
  .pass_count(pass_count)
);

// File: tb/spad_serializer_test.sv
`timescale 1ns/1ps
module spad_serializer_test;

  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int PCW   = 6;
  localparam int WORDS = 1 << AW;

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic                req_ready;
  logic                req_store;
  logic [LANES-1:0]    req_mask;
  logic [LANES*AW-1:0] req_addr;
  logic [LANES*DW-1:0] req_wdata;
  logic                done;
  logic [LANES*DW-1:0] rdata;
  logic [PCW-1:0]      pass_count;

  spad_serializer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_mask(req_mask), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .pass_count(pass_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0]       shadow [WORDS];
  int                  lane_addr [LANES];
  logic [DW-1:0]       lane_wd   [LANES];
  logic [LANES-1:0]    lane_mask;

  logic [LANES*DW-1:0] exp_data [$];
  int                  exp_pass [$];
  string               exp_tag  [$];
  int                  acc_cyc  [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: model the expected result, push it, then present the request
  task automatic issue(input bit store, input string tag);
    logic [LANES*DW-1:0] ed;
    int                  passes;
    ed     = '0;
    passes = 0;
    for (int b = 0; b < 32; b++) begin
      int n = 0;
      for (int l = 0; l < LANES; l++) begin
        if (lane_mask[l] && (lane_addr[l] % 32 == b)) begin
          bit seen = 0;
          for (int k = 0; k < l; k++)
            if (lane_mask[k] && lane_addr[k] == lane_addr[l]) seen = 1;
          if (!seen) n++;
        end
      end
      if (n > passes) passes = n;
    end
    for (int l = 0; l < LANES; l++) begin
      if (lane_mask[l]) begin
        if (store) shadow[lane_addr[l]] = lane_wd[l];
        else       ed[l*DW +: DW] = shadow[lane_addr[l]];
      end
    end
    exp_data.push_back(ed);
    exp_pass.push_back(passes);
    exp_tag.push_back(tag);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_store = store;
    req_mask  = lane_mask;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW]  = AW'(lane_addr[l]);
      req_wdata[l*DW +: DW] = lane_wd[l];
    end
    @(posedge clk);
    @(negedge clk);
    acc_cyc.push_back(cyc);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7", "ready after accept", longint'(req_ready), 0);
  endtask

  task automatic wait_idle();
    while (exp_pass.size() != 0) @(negedge clk);
  endtask

  // monitor: pop and compare on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_pass.size() == 0) begin
        check(0, "R7", "unexpected done", 1, 0);
      end else begin
        logic [LANES*DW-1:0] ed;
        int    ep, ac;
        string tg;
        ed = exp_data.pop_front();
        ep = exp_pass.pop_front();
        tg = exp_tag.pop_front();
        ac = acc_cyc.pop_front();
        checks++;
        if (rdata !== ed) begin
          errors++;
          $display("FAIL %s rdata: actual=%h expected=%h", tg, rdata, ed);
        end
        check(int'(pass_count) == ep, tg, "pass count", longint'(pass_count), ep);
        check(cyc - ac == ep + 1, "R7", "done latency", cyc - ac, ep + 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", cyc, 0);
    finish_run();
  end

  initial begin
    req_valid = 1'b0;
    req_store = 1'b0;
    req_mask  = '0;
    req_addr  = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(req_ready == 1'b1, "R7", "reset ready", longint'(req_ready), 1);
    check(done == 1'b0, "R7", "reset done", longint'(done), 0);
    check(pass_count == '0, "R4", "reset pass count", longint'(pass_count), 0);
    check(rdata == '0, "R5", "reset rdata", 0, 0);

    // R1 R2 R10: fill every word, one bank-spread store per row
    for (int r = 0; r < WORDS / 32; r++) begin
      lane_mask = '1;
      for (int l = 0; l < LANES; l++) begin
        lane_addr[l] = r * 32 + l;
        lane_wd[l]   = 32'hA500_0000 ^ (lane_addr[l] * 32'h9E37);
      end
      issue(1, "R10");
    end

    // R1 R2: load a row back, lanes reversed over the banks
    lane_mask = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = 96 + (31 - l);
    issue(0, "R1");

    // R3: broadcast of one word to every lane
    for (int l = 0; l < LANES; l++) lane_addr[l] = 5;
    issue(0, "R3");

    // R4: every lane a different row of bank 0, store then load
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = l * 32;
      lane_wd[l]   = 32'h0BAD_0000 + l;
    end
    issue(1, "R4");
    issue(0, "R4");

    // R4 R3: three distinct words in bank 0 plus a repeat, rest spread
    for (int l = 0; l < LANES; l++) lane_addr[l] = 320 + l;
    lane_addr[0] = 0;
    lane_addr[1] = 32;
    lane_addr[2] = 0;
    lane_addr[3] = 64;
    issue(0, "R4");

    // R2 R3: pairs share addresses in distinct banks
    for (int l = 0; l < LANES; l++) lane_addr[l] = 512 + (l / 2) * 33 % 32 + 32 * (l % 4 / 2 * 0);
    issue(0, "R2");

    // R5: inactive lanes conflict heavily but are ignored
    lane_mask = 32'hAAAA_AAAA;
    for (int l = 0; l < LANES; l++) lane_addr[l] = (l % 2) ? (640 + l) : (l * 32);
    issue(0, "R5");

    // R5: masked-off store lane must not write
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l] = 704 + l;
      lane_wd[l]   = 32'h5A5A_0000 + l;
    end
    lane_mask = 32'hFFFF_FFFE;
    lane_wd[0] = 32'hDEAD_BEEF;
    issue(1, "R5");
    lane_mask = '1;
    issue(0, "R5");

    // R6: three lanes store one word, highest lane wins
    lane_mask = '0;
    lane_mask[3] = 1'b1; lane_mask[10] = 1'b1; lane_mask[20] = 1'b1;
    lane_addr[3] = 900; lane_addr[10] = 900; lane_addr[20] = 900;
    lane_wd[3] = 32'h1111_1111; lane_wd[10] = 32'h2222_2222; lane_wd[20] = 32'h3333_3333;
    issue(1, "R6");
    lane_mask = 32'h0000_0001;
    lane_addr[0] = 900;
    issue(0, "R6");

    // R8: back-to-back requests whose addresses would collide across requests
    lane_mask = 32'h0000_0001;
    lane_addr[0] = 0;
    lane_wd[0]   = 32'hCAFE_0001;
    issue(1, "R8");
    lane_addr[0] = 32;
    lane_wd[0]   = 32'hCAFE_0002;
    issue(1, "R8");
    lane_addr[0] = 0;
    issue(0, "R8");
    lane_addr[0] = 32;
    issue(0, "R8");

    // R9: empty mask
    lane_mask = '0;
    for (int l = 0; l < LANES; l++) lane_addr[l] = l * 32;
    issue(0, "R9");

    wait_idle();
    repeat (3) @(negedge clk);
    check(exp_pass.size() == 0, "R7", "pending results", exp_pass.size(), 0);
    finish_run();
  end

endmodule